// File: doc/BRIEF.md
# Dual-Rate Prescaler and Programmable Divider

This block derives two output rates from one master clock. Rate A uses a power-of-two prescaler, or it passes the master rate straight through. Rate B runs a second power-of-two prescaler in series with a ten-bit programmable divider, and a bypass bit can take the divider out of the path. Each rate leaves the block as two registered signals in the master-clock domain. One is a single-cycle `tick` that marks the start of every output period, for use as a clock enable. The other is a square-wave `lvl` level that a neighbouring output stage can drive.

Configuration arrives one byte at a time. Each 16-bit word is a control word or a divisor word, and it is sent as a first byte and then a second byte. The control word also carries power, enable and select bits. The block decodes these and presents them to neighbouring logic. A control word whose reserved bit is set is discarded and reported. A new rate never cuts a running period short: the period in progress finishes at its old length.

Top module: `pd_clk_divider`

## Requirements
- R1: While `rst` is high and in the cycle after it, both ticks, both levels and `cfg_err` are 0. The decoded fields reset to select=1, enable=1 and both power bits 0, with both prescaler codes 0, bypass 0 and N=0. With these values rate A has period 1 and rate B has period 2.
- R2: A cycle with `cfg_wr`=1 and `cfg_first`=1 stores `cfg_data` as the high byte. A cycle with `cfg_wr`=1 and `cfg_first`=0 commits {stored byte, `cfg_data`} to the control word (`cfg_word`=0) or to the divisor word (`cfg_word`=1). The committed value is visible in the cycle after that edge, and a divisor write leaves the control fields unchanged.
- R3: Control word bit positions are as follows. Bit 15 is reserved and must be 0. Bits 14, 13, 12 and 11 drive `ctl_pdn1`, `ctl_pdn0`, `ctl_sel0` and `ctl_en0`. Bits 10:9 are the rate-A prescaler code, bits 8:7 are the rate-B prescaler code, and bit 6 is the bypass bit. Bits 5:0 are ignored.
- R4: Prescaler codes 0, 1, 2 and 3 divide by 1, 2, 4 and 8.
- R5: The rate-A period is 1 master cycle when select is 0. When select is 1 it is the rate-A prescaler ratio.
- R6: With bypass 0, the rate-B period is the rate-B prescaler ratio times (N+2), where N is divisor word bits 15:6. This gives 2 to 8200 cycles.
- R7: With bypass 1, the rate-B period equals the rate-B prescaler ratio, and N has no effect.
- R8: Each tick is high for exactly one cycle, at the first cycle of every period. The level is high for the first floor(D/2) cycles of a D-cycle period and low for the rest, so it is always low when D=1.
- R9: A rate change takes effect only when the current period ends. Every period runs with the divisor that was in force in the cycle before it started.
- R10: A control word with bit 15 set changes no field. It raises `cfg_err` for exactly the one cycle after its commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_wr | input | 1 | configuration byte valid |
| cfg_word | input | 1 | 0 = control word, 1 = divisor word |
| cfg_first | input | 1 | 1 = high (first) byte, 0 = low byte that commits |
| cfg_data | input | 8 | configuration byte |
| out0_tick | output | 1 | rate A period-start enable |
| out0_lvl | output | 1 | rate A square wave |
| out1_tick | output | 1 | rate B period-start enable |
| out1_lvl | output | 1 | rate B square wave |
| ctl_pdn1 | output | 1 | decoded power bit for the B control input |
| ctl_pdn0 | output | 1 | decoded power bit for the A control input |
| ctl_sel0 | output | 1 | decoded rate A select |
| ctl_en0 | output | 1 | decoded rate A enable |
| cfg_err | output | 1 | one-cycle pulse: control word rejected |

## Verification
A write commits on the rising edge that samples its second byte. The decoded fields and `cfg_err` are due one cycle later, and the bench reads them at the falling edge that follows the commit. Rate changes are due at the next period start after the commit, which may be thousands of cycles away. For this reason the scoreboard captures the expected divisor from its own register model at the falling edge just before each tick and queues it. At the next tick it compares that entry with the measured period length and the count of high cycles. A commit that lands on a period's final edge is therefore attributed to the following period, which is what R9 requires.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int N_W    = 10;
  localparam int CODE_W = 2;
  localparam int WORD_W = 16;

  // control word layout (decoded by neighbours, kept fixed)
  localparam int B_RSV  = 15;
  localparam int B_PDN1 = 14;
  localparam int B_PDN0 = 13;
  localparam int B_SEL0 = 12;
  localparam int B_EN0  = 11;
  localparam int B_P0   = 10;   // msb of rate A code
  localparam int B_P1   = 8;    // msb of rate B code
  localparam int B_BYP  = 6;

  localparam logic [WORD_W-1:0] CTRL_RST = 16'h1800;

  typedef struct packed {
    logic              pdn1;
    logic              pdn0;
    logic              sel0;
    logic              en0;
    logic [CODE_W-1:0] p0;
    logic [CODE_W-1:0] p1;
    logic              byp;
  } ctrl_t;
endpackage

// File: rtl/pd_cfg_regs.sv
module pd_cfg_regs
  import pd_pkg::*;
#(
  parameter int              NW    = N_W,
  parameter logic [NW-1:0]   RST_N = '0
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_word,
  input  logic          cfg_first,
  input  logic [7:0]    cfg_data,
  output ctrl_t         ctrl_q,
  output logic [NW-1:0] n_q,
  output logic          cfg_err
);
  logic [7:0]        stage_q;
  logic [WORD_W-1:0] word;
  logic              commit;
  logic              dc_unused;
  ctrl_t             ctrl_rst;
  ctrl_t             ctrl_nx;

  always_comb begin
    word      = {stage_q, cfg_data};
    commit    = cfg_wr && !cfg_first;
    dc_unused = ^word[B_BYP-1:0];
    ctrl_rst  = '{pdn1: CTRL_RST[B_PDN1], pdn0: CTRL_RST[B_PDN0],
                  sel0: CTRL_RST[B_SEL0], en0: CTRL_RST[B_EN0],
                  p0: CTRL_RST[B_P0 -: CODE_W], p1: CTRL_RST[B_P1 -: CODE_W],
                  byp: CTRL_RST[B_BYP]};
    ctrl_nx   = '{pdn1: word[B_PDN1], pdn0: word[B_PDN0],
                  sel0: word[B_SEL0], en0: word[B_EN0],
                  p0: word[B_P0 -: CODE_W], p1: word[B_P1 -: CODE_W],
                  byp: word[B_BYP]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      ctrl_q  <= ctrl_rst;
      n_q     <= RST_N;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= 1'b0;
      if (cfg_wr && cfg_first) stage_q <= cfg_data;
      if (commit) begin
        if (cfg_word) begin
          n_q <= word[WORD_W-1 -: NW];
        end else if (word[B_RSV]) begin
          cfg_err <= 1'b1;
        end else begin
          ctrl_q <= ctrl_nx;
        end
      end
    end
  end

  AST_RSV_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $stable(ctrl_q)); // R10
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !cfg_err); // R10
endmodule

// File: rtl/pd_ratio.sv
module pd_ratio #(
  parameter int NW = 10,
  parameter int CW = 2,
  parameter int DW = NW + 1 + (2**CW - 1)
)(
  input  logic          sel0,
  input  logic          byp,
  input  logic [CW-1:0] p0,
  input  logic [CW-1:0] p1,
  input  logic [NW-1:0] n,
  output logic [DW-1:0] d0,
  output logic [DW-1:0] d1
);
  logic [NW:0] base;

  always_comb begin
    base = byp ? (NW+1)'(1) : ({1'b0, n} + (NW+1)'(2));
    d1   = DW'(base) << p1;
    d0   = sel0 ? (DW'(1) << p0) : DW'(1);
  end
endmodule

// File: rtl/pd_div_core.sv
module pd_div_core #(
  parameter int DW = 14
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d_req,
  output logic          tick,
  output logic          lvl
);
  logic [DW-1:0] cnt_q, d_act_q, cnt_nx, d_nx, d_safe;
  logic          wrap;

  always_comb begin
    d_safe = (d_req == '0) ? DW'(1) : d_req;
    wrap   = (cnt_q == d_act_q - 1'b1);
    cnt_nx = wrap ? '0 : cnt_q + 1'b1;
    d_nx   = wrap ? d_safe : d_act_q;
  end

  // reset parks the counter on a period end so the first edge starts a period
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      d_act_q <= DW'(1);
      tick    <= 1'b0;
      lvl     <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      d_act_q <= d_nx;
      tick    <= (cnt_nx == '0);
      lvl     <= (cnt_nx < (d_nx >> 1));
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < d_act_q); // R8
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(d_act_q)); // R9
  AST_START_LEVEL: assert property (@(posedge clk) disable iff (rst)
    tick |-> (lvl == (d_act_q > DW'(1)))); // R8
endmodule

// File: rtl/pd_clk_divider.sv
module pd_clk_divider
  import pd_pkg::*;
#(
  parameter int NW = N_W,
  parameter int CW = CODE_W
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic       cfg_word,
  input  logic       cfg_first,
  input  logic [7:0] cfg_data,
  output logic       out0_tick,
  output logic       out0_lvl,
  output logic       out1_tick,
  output logic       out1_lvl,
  output logic       ctl_pdn1,
  output logic       ctl_pdn0,
  output logic       ctl_sel0,
  output logic       ctl_en0,
  output logic       cfg_err
);
  localparam int DW    = NW + 1 + (2**CW - 1);
  localparam int N_OUT = 2;

  ctrl_t          ctrl;
  logic [NW-1:0]  n_val;
  logic [DW-1:0]  dreq [N_OUT];
  logic [N_OUT-1:0] tk, lv;

  pd_cfg_regs #(.NW(NW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .cfg_first(cfg_first), .cfg_data(cfg_data),
    .ctrl_q(ctrl), .n_q(n_val), .cfg_err(cfg_err)
  );

  pd_ratio #(.NW(NW), .CW(CW), .DW(DW)) u_ratio (
    .sel0(ctrl.sel0), .byp(ctrl.byp), .p0(ctrl.p0), .p1(ctrl.p1),
    .n(n_val), .d0(dreq[0]), .d1(dreq[1])
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    pd_div_core #(.DW(DW)) u_core (
      .clk(clk), .rst(rst), .d_req(dreq[g]), .tick(tk[g]), .lvl(lv[g])
    );
  end

  assign out0_tick = tk[0];
  assign out0_lvl  = lv[0];
  assign out1_tick = tk[1];
  assign out1_lvl  = lv[1];
  assign ctl_pdn1  = ctrl.pdn1;
  assign ctl_pdn0  = ctrl.pdn0;
  assign ctl_sel0  = ctrl.sel0;
  assign ctl_en0   = ctrl.en0;
endmodule

// File: tb/pd_clk_divider_tb_top.sv
module pd_clk_divider_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_word = 1'b0, cfg_first = 1'b0;
  logic [7:0] cfg_data = '0;
  logic out0_tick, out0_lvl, out1_tick, out1_lvl;
  logic ctl_pdn1, ctl_pdn0, ctl_sel0, ctl_en0, cfg_err;

  always #10 clk = ~clk;   // 50 MHz

  pd_clk_divider dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .cfg_first(cfg_first), .cfg_data(cfg_data),
    .out0_tick(out0_tick), .out0_lvl(out0_lvl),
    .out1_tick(out1_tick), .out1_lvl(out1_lvl),
    .ctl_pdn1(ctl_pdn1), .ctl_pdn0(ctl_pdn0), .ctl_sel0(ctl_sel0),
    .ctl_en0(ctl_en0), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_ctrl = 16'h1800;
  int m_n = 0;
  string mon_tag = "R6";
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int snap0 = 1, snap1 = 2;
  int q0[$], q1[$];
  int len[2], hi[2];
  bit started[2];

  function automatic int f_d0(input logic [15:0] c);
    return c[12] ? (1 << c[10:9]) : 1;
  endfunction
  function automatic int f_d1(input logic [15:0] c, input int n);
    return (c[6] ? 1 : (n + 2)) << c[8:7];
  endfunction
  function automatic logic [15:0] mk_ctrl(input bit rsv, input bit pd1, input bit pd0,
      input bit s0, input bit e0, input int p0, input int p1, input bit byp);
    logic [15:0] v;
    v = '0;
    v[15] = rsv; v[14] = pd1; v[13] = pd0; v[12] = s0; v[11] = e0;
    v[10:9] = 2'(p0); v[8:7] = 2'(p1); v[6] = byp; v[5:0] = 6'h2a;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_ctl(input string tag, input logic [15:0] c);
    chk({ctl_pdn1, ctl_pdn0, ctl_sel0, ctl_en0} == c[14:11], tag,
        {ctl_pdn1, ctl_pdn0, ctl_sel0, ctl_en0}, c[14:11]);
  endtask

  task automatic wr_word(input bit w, input logic [15:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = w; cfg_first = 1'b1; cfg_data = v[15:8];
    @(negedge clk);
    cfg_first = 1'b0; cfg_data = v[7:0];
    @(posedge clk);
    if (w) m_n = int'(v[15:6]);
    else if (!v[15]) m_ctrl = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(cfg_err == (!w && v[15]), (!w && v[15]) ? "R10 err pulse" : "R2 no err",
        cfg_err, (!w && v[15]));
    @(negedge clk);
    chk(cfg_err == 1'b0, "R10 err one cycle", cfg_err, 0);
  endtask

  // scoreboard: queue the divisor in force before each period start, compare at the next start
  task automatic step(input int k, input logic tk, input logic lv, input int snapd);
    int e;
    if (tk) begin
      if (started[k]) begin
        if (k == 0) e = (q0.size() == 0) ? -1 : q0.pop_front();
        else        e = (q1.size() == 0) ? -1 : q1.pop_front();
        chk(len[k] == e, $sformatf("%s out%0d period", mon_tag, k), len[k], e);
        chk(hi[k] == e / 2, $sformatf("R8 out%0d high time", k), hi[k], e / 2);
      end
      if (k == 0) q0.push_back(snapd); else q1.push_back(snapd);
      started[k] = 1'b1;
      len[k] = 1;
      hi[k] = lv ? 1 : 0;
    end else if (started[k]) begin
      len[k]++;
      hi[k] += lv ? 1 : 0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && mon_on) begin
      step(0, out0_tick, out0_lvl, snap0);
      step(1, out1_tick, out1_lvl, snap1);
    end
    snap0 = f_d0(m_ctrl);
    snap1 = f_d1(m_ctrl, m_n);
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({out0_tick, out0_lvl, out1_tick, out1_lvl, cfg_err} == 5'b0, "R1 reset outputs",
        {out0_tick, out0_lvl, out1_tick, out1_lvl, cfg_err}, 0);
    chk_ctl("R1 reset fields", 16'h1800);
    rst = 1'b0; mon_on = 1'b1;
    @(negedge clk);
    chk(out0_tick && out1_tick, "R8 first tick", {out0_tick, out1_tick}, 3);
    chk(out1_lvl == 1'b1 && out0_lvl == 1'b0, "R1 first levels", {out0_lvl, out1_lvl}, 1);
    repeat (20) @(negedge clk);

    mon_tag = "R4";
    wr_word(1'b0, mk_ctrl(0, 1, 0, 1, 0, 2, 1, 0));
    chk_ctl("R3 fields", mk_ctrl(0, 1, 0, 1, 0, 2, 1, 0));
    wr_word(1'b1, 16'(5 << 6) | 16'h003f);
    chk_ctl("R2 divisor write keeps fields", mk_ctrl(0, 1, 0, 1, 0, 2, 1, 0));
    repeat (100) @(negedge clk);

    mon_tag = "R8";
    wr_word(1'b1, 16'(3 << 6));
    wr_word(1'b0, mk_ctrl(0, 0, 1, 1, 1, 3, 0, 0));
    chk_ctl("R3 fields b", mk_ctrl(0, 0, 1, 1, 1, 3, 0, 0));
    repeat (60) @(negedge clk);

    mon_tag = "R5";
    wr_word(1'b0, mk_ctrl(0, 0, 0, 0, 1, 3, 0, 0));
    repeat (30) @(negedge clk);

    mon_tag = "R7";
    wr_word(1'b0, mk_ctrl(0, 0, 0, 1, 1, 1, 3, 1));
    wr_word(1'b1, 16'(100 << 6));
    repeat (80) @(negedge clk);

    mon_tag = "R10";
    wr_word(1'b0, mk_ctrl(1, 1, 1, 0, 0, 0, 0, 0));
    chk_ctl("R10 rejected word", mk_ctrl(0, 0, 0, 1, 1, 1, 3, 1));
    repeat (50) @(negedge clk);

    mon_tag = "R9";
    wr_word(1'b0, mk_ctrl(0, 0, 0, 1, 1, 0, 0, 0));
    wr_word(1'b1, 16'(1023 << 6));
    repeat (1200) @(negedge clk);
    wr_word(1'b1, 16'(0 << 6));
    repeat (1200) @(negedge clk);

    mon_tag = "R6";
    wr_word(1'b0, mk_ctrl(0, 0, 0, 1, 1, 0, 3, 0));
    wr_word(1'b1, 16'(1023 << 6));
    repeat (20000) @(negedge clk);

    mon_tag = "R4";
    wr_word(1'b0, mk_ctrl(0, 0, 0, 1, 1, 1, 2, 0));
    wr_word(1'b1, 16'(7 << 6));
    repeat (9000) @(negedge clk);

    mon_on = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule